// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block controls a port of general-purpose pins between a software register file and the pad ring. For each pin it keeps five bits: an output data latch, a direction bit, a pull-up enable, a drive-strength select and a slew-control enable. From these it produces the pad output enable, the pad output value, the pull-up enable, the drive select and the slew enable. It also returns the port read value, taken from either the output latch or a two-flop synchronized copy of the pad input.

Any pin can be taken over by an on-chip peripheral. While it is taken over, the peripheral's output enable and output data drive the pad in place of the direction bit and the output latch. The pull-up, drive-strength and slew selections still come from software. The port read value still follows the direction bit, not the direction the peripheral has chosen. Optionally the highest-numbered pin is input-only: it never drives, and its drive and slew outputs stay inactive.

Top module: `gpio_port`

## Requirements
- R1: Reset is asynchronous and active low. Afterwards all five registers are zero, so every pin is an undriven input: pad_oe, pad_out, pad_pull_en, pad_drive_hi and pad_slew_en are all zero.
- R2: A write with wr_en high stores wr_data at the next rising clock edge into the register chosen by wr_sel: 0 output latch, 1 direction, 2 pull-up enable, 3 drive select, 4 slew enable. The codes 5, 6 and 7 change nothing.
- R3: On a pin without peripheral override, pad_oe equals the direction bit and pad_out equals the output latch bit.
- R4: On a pin whose direction bit is 1, rd_data returns the output latch bit.
- R5: On a pin whose direction bit is 0, rd_data returns pad_in as it was sampled two rising edges earlier. After one edge it still shows the older value.
- R6: pad_pull_en is the pull-up enable bit gated off whenever pad_oe of that pin is 1.
- R7: pad_drive_hi and pad_slew_en follow the drive and slew register bits on every bidirectional pin, whether software or a peripheral owns it.
- R8: While periph_en of a pin is 1, pad_oe equals periph_oe and pad_out equals periph_out for that pin.
- R9: While a peripheral owns a pin, rd_data of that pin still follows the direction bit as in R4 and R5.
- R10: With HAS_INPUT_ONLY set, pin N_PINS-1 is input-only. Its direction bit always reads as 0. Its pad_oe, pad_out, pad_drive_hi and pad_slew_en are forced to 0, even under peripheral override. Its rd_data always comes from the synchronized pad input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | N_PINS | Write data, one bit per pin |
| rd_data | output | N_PINS | Port read value |
| periph_en | input | N_PINS | Peripheral takes over the pin |
| periph_oe | input | N_PINS | Peripheral output enable |
| periph_out | input | N_PINS | Peripheral output data |
| pad_in | input | N_PINS | Pad input level |
| pad_oe | output | N_PINS | Pad output enable |
| pad_out | output | N_PINS | Pad output value |
| pad_pull_en | output | N_PINS | Pad pull-up enable |
| pad_drive_hi | output | N_PINS | High drive strength select |
| pad_slew_en | output | N_PINS | Slew-rate control enable |

## Verification
Two things can happen in the same cycle: a peripheral takes over a group of pins, and software rewrites the output latch while the pad input changes. The bench provokes this from one falling edge. It raises periph_en on some pins, writes new latch data and changes pad_in all at once. It then checks that pad_oe and pad_out on the taken pins show the peripheral's values. The read value must show the new latch data on the pins whose direction bit is 1, and the new pad level, after exactly two edges, on the pins whose direction bit is 0. One of the taken pins is a direction-0 pin that the peripheral drives, which shows that the read path ignores the peripheral's direction.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_PULL  = 3'd2,
        SEL_DRIVE = 3'd3,
        SEL_SLEW  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int                N_PINS   = 8,
    parameter logic [N_PINS-1:0] DIR_MASK = {N_PINS{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] data_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] pull_q,
    output logic [N_PINS-1:0] drive_q,
    output logic [N_PINS-1:0] slew_q
);

    typedef struct packed {
        logic [N_PINS-1:0] data;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] pull;
        logic [N_PINS-1:0] drive;
        logic [N_PINS-1:0] slew;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_DATA:  r_d.data  = wr_data;
                SEL_DIR:   r_d.dir   = wr_data & DIR_MASK;
                SEL_PULL:  r_d.pull  = wr_data;
                SEL_DRIVE: r_d.drive = wr_data;
                SEL_SLEW:  r_d.slew  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_q  = r_q.data;
    assign dir_q   = r_q.dir;
    assign pull_q  = r_q.pull;
    assign drive_q = r_q.drive;
    assign slew_q  = r_q.slew;

    // R1: every register is cleared while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_regs_cleared: assert (r_q == '0)
                else $error("registers not cleared in reset");
        end
    end

    // R2: a direction write lands on the next edge, masked
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> (dir_q == ($past(wr_data) & DIR_MASK)))
        else $error("direction write lost");

    // R2: unused select codes leave every register unchanged
    a_r2_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > 3'd4) |=> $stable(r_q))
        else $error("unused select changed a register");

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] d_in,
    output logic [N_PINS-1:0] d_sync
);

    typedef struct packed {
        logic [N_PINS-1:0] s1;
        logic [N_PINS-1:0] s2;
        logic [1:0]        warm;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d_in;
        s_d.s2 = s_q.s1;
        if (s_q.warm != 2'd2) s_d.warm = s_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign d_sync = s_q.s2;

    // R5: the synchronized value is the input from two edges back
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm == 2'd2) |-> (d_sync == $past(d_in, 2)))
        else $error("synchronizer latency wrong");

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter bit INPUT_ONLY = 1'b0
) (
    input  logic dir,
    input  logic data,
    input  logic pull,
    input  logic drive,
    input  logic slew,
    input  logic periph_en,
    input  logic periph_oe,
    input  logic periph_out,
    input  logic sync_in,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_pull,
    output logic pad_drive,
    output logic pad_slew,
    output logic rd
);

    logic oe_sel, out_sel;

    always_comb begin
        oe_sel  = periph_en ? periph_oe  : dir;
        out_sel = periph_en ? periph_out : data;
        if (INPUT_ONLY) begin
            pad_oe    = 1'b0;
            pad_out   = 1'b0;
            pad_drive = 1'b0;
            pad_slew  = 1'b0;
            rd        = sync_in;
        end else begin
            pad_oe    = oe_sel;
            pad_out   = out_sel;
            pad_drive = drive;
            pad_slew  = slew;
            rd        = dir ? data : sync_in;
        end
        pad_pull = pull & ~pad_oe;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int N_PINS         = 8,
    parameter bit HAS_INPUT_ONLY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] rd_data,
    input  logic [N_PINS-1:0] periph_en,
    input  logic [N_PINS-1:0] periph_oe,
    input  logic [N_PINS-1:0] periph_out,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pull_en,
    output logic [N_PINS-1:0] pad_drive_hi,
    output logic [N_PINS-1:0] pad_slew_en
);

    localparam logic [N_PINS-1:0] BIDIR_MASK = HAS_INPUT_ONLY ?
        {1'b0, {(N_PINS-1){1'b1}}} : {N_PINS{1'b1}};

    logic [N_PINS-1:0] data_q, dir_q, pull_q, drive_q, slew_q, sync_in;

    gpio_regs #(.N_PINS(N_PINS), .DIR_MASK(BIDIR_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .drive_q (drive_q),
        .slew_q  (slew_q)
    );

    gpio_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (sync_in)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        localparam bit IN_ONLY = HAS_INPUT_ONLY && (i == N_PINS - 1);
        gpio_pin_mux #(.INPUT_ONLY(IN_ONLY)) u_mux (
            .dir        (dir_q[i]),
            .data       (data_q[i]),
            .pull       (pull_q[i]),
            .drive      (drive_q[i]),
            .slew       (slew_q[i]),
            .periph_en  (periph_en[i]),
            .periph_oe  (periph_oe[i]),
            .periph_out (periph_out[i]),
            .sync_in    (sync_in[i]),
            .pad_oe     (pad_oe[i]),
            .pad_out    (pad_out[i]),
            .pad_pull   (pad_pull_en[i]),
            .pad_drive  (pad_drive_hi[i]),
            .pad_slew   (pad_slew_en[i]),
            .rd         (rd_data[i])
        );
    end

    // R6: the pull-up is never on while the pad is driven
    a_r6_no_pull_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0)
        else $error("pull-up active on a driven pad");

    // R8: a peripheral that owns a pin sets its direction
    a_r8_periph_direction: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ periph_oe) & periph_en & BIDIR_MASK) == '0)
        else $error("peripheral direction not applied");

    // R9: read of an output pin gives the latch regardless of owner
    a_r9_read_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data ^ data_q) & dir_q) == '0)
        else $error("read of output pin not from latch");

    // R10: input-only pin stays quiet
    if (HAS_INPUT_ONLY) begin : g_in_only_chk
        a_r10_input_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[N_PINS-1] && !pad_drive_hi[N_PINS-1] && !pad_slew_en[N_PINS-1])
            else $error("input-only pin drives");
    end

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic [N-1:0] periph_en = '0, periph_oe = '0, periph_out = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_oe, pad_out, pad_pull_en, pad_drive_hi, pad_slew_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.N_PINS(N), .HAS_INPUT_ONLY(1'b1)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .periph_en    (periph_en),
        .periph_oe    (periph_oe),
        .periph_out   (periph_out),
        .pad_in       (pad_in),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pad_pull_en  (pad_pull_en),
        .pad_drive_hi (pad_drive_hi),
        .pad_slew_en  (pad_slew_en)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [N-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pull", pad_pull_en, 8'h00);
        check("R1 drive", pad_drive_hi, 8'h00);
        check("R1 slew", pad_slew_en, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_gpio_out();
        write_reg(3'd1, 8'h0F);
        write_reg(3'd0, 8'hA5);
        check("R3 pad_oe", pad_oe, 8'h0F);
        check("R3 pad_out", pad_out, 8'h25);
        check("R4 rd_data latch", rd_data, 8'h05);
    endtask

    task automatic t_unused_sel();
        write_reg(3'd5, 8'hFF);
        write_reg(3'd6, 8'h00);
        write_reg(3'd7, 8'h00);
        check("R2 unused pad_oe", pad_oe, 8'h0F);
        check("R2 unused pad_out", pad_out, 8'h25);
        check("R2 unused pull", pad_pull_en, 8'h00);
    endtask

    task automatic t_gpio_in();
        @(negedge clk);
        pad_in = 8'h3C;
        @(negedge clk);
        check("R5 one edge", rd_data, 8'h05);
        @(negedge clk);
        check("R5 two edges", rd_data, 8'h35);
    endtask

    task automatic t_pull();
        write_reg(3'd2, 8'hFF);
        check("R6 pull gated", pad_pull_en, 8'hF0);
    endtask

    task automatic t_drive_slew();
        write_reg(3'd3, 8'hFF);
        write_reg(3'd4, 8'h55);
        check("R7 drive", pad_drive_hi, 8'h7F);
        check("R7 slew", pad_slew_en, 8'h55);
    endtask

    task automatic t_periph_same_cycle();
        @(negedge clk);
        periph_en = 8'h13; periph_oe = 8'h12; periph_out = 8'h12;
        pad_in = 8'h2C;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 pad_oe", pad_oe, 8'h1E);
        check("R8 pad_out", pad_out, 8'h12);
        check("R6 pull periph", pad_pull_en, 8'hE1);
        check("R7 drive periph", pad_drive_hi, 8'h7F);
        check("R9 rd one edge", rd_data, 8'h30);
        @(negedge clk);
        check("R9 rd two edges", rd_data, 8'h20);
        periph_en = 8'h00; periph_oe = 8'h00; periph_out = 8'h00;
        #1;
        check("R3 released pad_oe", pad_oe, 8'h0F);
    endtask

    task automatic t_input_only();
        @(negedge clk);
        periph_en = 8'h80; periph_oe = 8'h80; periph_out = 8'h80;
        pad_in = 8'hAC;
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 pad_oe", pad_oe, 8'h7F);
        check("R10 pad_out", pad_out, 8'h00);
        check("R10 drive", pad_drive_hi, 8'h7F);
        check("R10 rd_data", rd_data, 8'h80);
        check("R6 pull input-only", pad_pull_en, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpio_out();
        t_unused_sel();
        t_gpio_in();
        t_pull();
        t_drive_slew();
        t_periph_same_cycle();
        t_input_only();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule